// File: doc/BRIEF.md
# Flash Erase Controller with Region Protection

This block connects a small microcontroller's byte-wide register bus to an on-chip flash array. Software configures a control register, picks a page in a page-address register and writes a command byte. The block then issues one erase request toward the flash, either for a single page or for the whole array. It holds a busy signal for a fixed number of cycles while the erase runs. Page erases that would touch a protected boot area or a protected high area of memory are refused. So is any erase that software has not explicitly re-armed since the previous one.

A security bit can only ever be set. While it is set, the two region-protection bits can only be raised, so lowering any of them needs a hardware reset. The security state is driven out on a dedicated pin so that debug read logic can be shut off. A separate program-write-select output tells the data-write path whether external data writes go to flash or to RAM.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset the control register (address 0x20) reads 0x00 except bit 7, which always reflects the `preboot_i` input. The page register (0x21) reads 0x00, and `erase_busy_o`, `erase_err_o` and `sec_o` are 0.
- R2: Control bit 6 (security) is reset to 0 and can be set by a register write. A write of 0 to it leaves it unchanged. `sec_o` shows its value.
- R3: Control bits 4 (high-area protect) and 5 (boot-area protect) follow each write while security is 0. While security is 1, a write can set them but never clear them.
- R4: Writing the page register (0x21, 7-bit page number) arms a page erase. An accepted page erase disarms it, so a following page command without a fresh page write is refused.
- R5: A mass erase is accepted only when control bit 1 is 1. Accepting it clears that bit, which then reads back as 0.
- R6: With bit 4 set, a page erase of any page number greater than or equal to `ce_loc_i` is refused.
- R7: With bit 5 set, a page erase of any page number below `boot_size_i` is refused.
- R8: The command register (0x22) takes 0xAA as page erase and 0x55 as mass erase. Any other value causes neither a request nor an error.
- R9: A refused erase issues no request and sets `erase_err_o`, which stays 1 until reset.
- R10: An accepted erase pulses `erase_req_o` for one cycle, with `erase_mass_o` and `erase_page_o` (0 for mass) valid. `erase_busy_o` is 1 for exactly ERASE_CYCLES cycles. Commands written while busy are dropped without error.
- R11: `prog_wr_sel_o` equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational on address) |
| preboot_i | input | 1 | Preboot-active status, read at control bit 7 |
| ce_loc_i | input | 7 | First page of the high protected area |
| boot_size_i | input | 7 | Number of pages in the boot protected area |
| prog_wr_sel_o | output | 1 | 1: external data writes go to program flash |
| sec_o | output | 1 | Security active, gates external read paths |
| erase_req_o | output | 1 | One-cycle erase start pulse |
| erase_mass_o | output | 1 | Last request was a mass erase |
| erase_page_o | output | 7 | Page number of the last request |
| erase_busy_o | output | 1 | Erase in progress |
| erase_err_o | output | 1 | Sticky refused-erase flag |

## Verification
A register write is sampled at a rising edge, and every registered result takes effect at that same edge. This covers the control bits, the arm flags, `erase_req_o`, `erase_busy_o` and `erase_err_o`, so the bench reads them at the falling edge right after the write cycle. Read data is combinational and is sampled one time step after the address changes. A scoreboard queue holds the expected request, which is pushed before the command write, and a monitor pops it at the falling edge where `erase_req_o` is high; a pulse with an empty queue is a failure. Busy length is counted in falling-edge samples from the first one after the accepting edge and must equal ERASE_CYCLES.

// File: rtl/fec_pkg.sv
package fec_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CMD_PAGE_ERASE = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_MASS_ERASE = 8'h55;

    // control register bit positions (software depends on them)
    localparam int BIT_PWE  = 0;
    localparam int BIT_MEE  = 1;
    localparam int BIT_WPC  = 4;
    localparam int BIT_WPB  = 5;
    localparam int BIT_SEC  = 6;
    localparam int BIT_PRE  = 7;

    typedef struct packed {
        logic pwe;
        logic mee;
        logic wp_ce;
        logic wp_boot;
        logic sec;
    } ctrl_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PAGE = 2'd1,
        OP_MASS = 2'd2
    } op_e;

endpackage

// File: rtl/fec_regfile.sv
module fec_regfile
    import fec_pkg::*;
#(
    parameter int          PAGE_W    = 7,
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_PAGE = 8'h21
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              page_take_i,
    input  logic              mass_take_i,
    input  logic              preboot_i,
    output ctrl_t             ctrl_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              page_armed_o,
    output logic [DATA_W-1:0] ctrl_rd_o,
    output logic [DATA_W-1:0] page_rd_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [PAGE_W-1:0] page;
        logic              armed;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic wr_ctrl, wr_page;
    logic unused_wdata;

    assign wr_ctrl      = bus_we_i && (bus_addr_i == ADDR_CTRL);
    assign wr_page      = bus_we_i && (bus_addr_i == ADDR_PAGE);
    assign unused_wdata = ^bus_wdata_i;

    always_comb begin
        st_d = st_q;

        // erase acceptance consumes the arming
        if (page_take_i) begin
            st_d.armed = 1'b0;
        end
        if (mass_take_i) begin
            st_d.ctrl.mee = 1'b0;
        end

        if (wr_ctrl) begin
            st_d.ctrl.pwe = bus_wdata_i[BIT_PWE];
            st_d.ctrl.mee = bus_wdata_i[BIT_MEE];
            // security is set-only
            st_d.ctrl.sec = st_q.ctrl.sec | bus_wdata_i[BIT_SEC];
            // protection bits lock upward once security is on
            if (st_q.ctrl.sec) begin
                st_d.ctrl.wp_ce   = st_q.ctrl.wp_ce   | bus_wdata_i[BIT_WPC];
                st_d.ctrl.wp_boot = st_q.ctrl.wp_boot | bus_wdata_i[BIT_WPB];
            end else begin
                st_d.ctrl.wp_ce   = bus_wdata_i[BIT_WPC];
                st_d.ctrl.wp_boot = bus_wdata_i[BIT_WPB];
            end
        end

        if (wr_page) begin
            st_d.page  = bus_wdata_i[PAGE_W-1:0];
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rd_o          = '0;
        ctrl_rd_o[BIT_PWE] = st_q.ctrl.pwe;
        ctrl_rd_o[BIT_MEE] = st_q.ctrl.mee;
        ctrl_rd_o[BIT_WPC] = st_q.ctrl.wp_ce;
        ctrl_rd_o[BIT_WPB] = st_q.ctrl.wp_boot;
        ctrl_rd_o[BIT_SEC] = st_q.ctrl.sec;
        ctrl_rd_o[BIT_PRE] = preboot_i;
    end

    assign page_rd_o    = DATA_W'(st_q.page);
    assign ctrl_o       = st_q.ctrl;
    assign page_o       = st_q.page;
    assign page_armed_o = st_q.armed;

endmodule

// File: rtl/fec_guard.sv
module fec_guard #(
    parameter int PAGE_W = 7
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic              wp_ce_i,
    input  logic              wp_boot_i,
    input  logic [PAGE_W-1:0] ce_loc_i,
    input  logic [PAGE_W-1:0] boot_size_i,
    output logic              blocked_o
);

    logic hit_high, hit_boot;

    // page size is one unit of the limits, so page numbers compare directly
    always_comb begin
        hit_high  = wp_ce_i   && (page_i >= ce_loc_i);
        hit_boot  = wp_boot_i && (page_i <  boot_size_i);
        blocked_o = hit_high || hit_boot;
    end

endmodule

// File: rtl/fec_sequencer.sv
module fec_sequencer
    import fec_pkg::*;
#(
    parameter int          PAGE_W       = 7,
    parameter int          ERASE_CYCLES = 16,
    parameter int          ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_CMD = 8'h22
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              page_armed_i,
    input  logic              mass_en_i,
    input  logic              blocked_i,
    input  logic [PAGE_W-1:0] page_sel_i,
    output logic              page_take_o,
    output logic              mass_take_o,
    output logic              req_o,
    output logic              mass_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              busy_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              req;
        logic              mass;
        logic [PAGE_W-1:0] page;
        logic              err;
    } seq_st_t;

    seq_st_t st_d, st_q;
    op_e     op;
    logic    ok_page, ok_mass, refused;

    always_comb begin
        op = OP_NONE;
        if (bus_we_i && (bus_addr_i == ADDR_CMD) && !st_q.busy) begin
            if (bus_wdata_i == CMD_PAGE_ERASE) begin
                op = OP_PAGE;
            end else if (bus_wdata_i == CMD_MASS_ERASE) begin
                op = OP_MASS;
            end
        end
        ok_page = (op == OP_PAGE) && page_armed_i && !blocked_i;
        ok_mass = (op == OP_MASS) && mass_en_i;
        refused = (op != OP_NONE) && !ok_page && !ok_mass;
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (ok_page || ok_mass) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
            st_d.req  = 1'b1;
            st_d.mass = ok_mass;
            st_d.page = ok_mass ? '0 : page_sel_i;
        end

        if (refused) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_take_o = ok_page;
    assign mass_take_o = ok_mass;
    assign req_o       = st_q.req;
    assign mass_o      = st_q.mass;
    assign page_o      = st_q.page;
    assign busy_o      = st_q.busy;
    assign err_o       = st_q.err;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import fec_pkg::*;
#(
    parameter int          PAGE_W       = 7,
    parameter int          ERASE_CYCLES = 16,
    parameter int          ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_PAGE = 8'h21,
    parameter logic [ADDR_W-1:0] ADDR_CMD  = 8'h22
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              preboot_i,
    input  logic [PAGE_W-1:0] ce_loc_i,
    input  logic [PAGE_W-1:0] boot_size_i,
    output logic              prog_wr_sel_o,
    output logic              sec_o,
    output logic              erase_req_o,
    output logic              erase_mass_o,
    output logic [PAGE_W-1:0] erase_page_o,
    output logic              erase_busy_o,
    output logic              erase_err_o
);

    ctrl_t             ctrl;
    logic [PAGE_W-1:0] page_sel;
    logic              page_armed;
    logic              page_take, mass_take, blocked;
    logic [DATA_W-1:0] ctrl_rd, page_rd;

    fec_regfile #(
        .PAGE_W    (PAGE_W),
        .ADDR_W    (ADDR_W),
        .ADDR_CTRL (ADDR_CTRL),
        .ADDR_PAGE (ADDR_PAGE)
    ) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bus_we_i     (bus_we_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .page_take_i  (page_take),
        .mass_take_i  (mass_take),
        .preboot_i    (preboot_i),
        .ctrl_o       (ctrl),
        .page_o       (page_sel),
        .page_armed_o (page_armed),
        .ctrl_rd_o    (ctrl_rd),
        .page_rd_o    (page_rd)
    );

    fec_guard #(
        .PAGE_W (PAGE_W)
    ) u_guard (
        .page_i      (page_sel),
        .wp_ce_i     (ctrl.wp_ce),
        .wp_boot_i   (ctrl.wp_boot),
        .ce_loc_i    (ce_loc_i),
        .boot_size_i (boot_size_i),
        .blocked_o   (blocked)
    );

    fec_sequencer #(
        .PAGE_W       (PAGE_W),
        .ERASE_CYCLES (ERASE_CYCLES),
        .ADDR_W       (ADDR_W),
        .ADDR_CMD     (ADDR_CMD)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bus_we_i     (bus_we_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .page_armed_i (page_armed),
        .mass_en_i    (ctrl.mee),
        .blocked_i    (blocked),
        .page_sel_i   (page_sel),
        .page_take_o  (page_take),
        .mass_take_o  (mass_take),
        .req_o        (erase_req_o),
        .mass_o       (erase_mass_o),
        .page_o       (erase_page_o),
        .busy_o       (erase_busy_o),
        .err_o        (erase_err_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_CTRL) begin
            bus_rdata_o = ctrl_rd;
        end else if (bus_addr_i == ADDR_PAGE) begin
            bus_rdata_o = page_rd;
        end
    end

    assign prog_wr_sel_o = ctrl.pwe;
    assign sec_o         = ctrl.sec;

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
    parameter int PAGE_W       = 7,
    parameter int ERASE_CYCLES = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sec_o,
    input logic              wp_ce,
    input logic              wp_boot,
    input logic              mee,
    input logic [PAGE_W-1:0] ce_loc_i,
    input logic [PAGE_W-1:0] boot_size_i,
    input logic              erase_req_o,
    input logic              erase_mass_o,
    input logic [PAGE_W-1:0] erase_page_o,
    input logic              erase_busy_o,
    input logic              erase_err_o
);

    int unsigned run_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_len <= 0;
        end else if (erase_busy_o) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R2: security never drops without reset
    a_r2_sec_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(sec_o));

    // R3: protect bits cannot fall while security was already on
    a_r3_wp_ce_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sec_o) && $past(wp_ce)) |-> wp_ce);
    a_r3_wp_boot_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sec_o) && $past(wp_boot)) |-> wp_boot);

    // R5: mass erase enable is gone once a mass erase started
    a_r5_mee_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (erase_req_o && erase_mass_o) |-> !mee);

    // R6: no page request inside the high protected area
    a_r6_high_area: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (erase_req_o && !erase_mass_o && wp_ce) |-> (erase_page_o < ce_loc_i));

    // R7: no page request inside the boot protected area
    a_r7_boot_area: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (erase_req_o && !erase_mass_o && wp_boot) |-> (erase_page_o >= boot_size_i));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(erase_err_o));

    // R10: request only when busy starts, single pulse, fixed busy length
    a_r10_req_starts_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_req_o |-> $rose(erase_busy_o));
    a_r10_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_req_o |=> !erase_req_o);
    a_r10_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(erase_busy_o) |-> (run_len == ERASE_CYCLES));

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(
    .PAGE_W       (PAGE_W),
    .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sec_o        (sec_o),
    .wp_ce        (ctrl.wp_ce),
    .wp_boot      (ctrl.wp_boot),
    .mee          (ctrl.mee),
    .ce_loc_i     (ce_loc_i),
    .boot_size_i  (boot_size_i),
    .erase_req_o  (erase_req_o),
    .erase_mass_o (erase_mass_o),
    .erase_page_o (erase_page_o),
    .erase_busy_o (erase_busy_o),
    .erase_err_o  (erase_err_o)
);

// File: tb/test_flash_erase_ctrl.sv
module test_flash_erase_ctrl;

    localparam int N  = 16;
    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_PAGE = 8'h21;
    localparam logic [7:0] A_CMD  = 8'h22;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       preboot = 1'b1;
    logic [6:0] ce_loc = 7'd100;
    logic [6:0] boot_size = 7'd8;
    logic       pws, sec, req, mass, busy, err;
    logic [6:0] epage;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    flash_erase_ctrl i_flash_erase_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .bus_we_i      (we),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .preboot_i     (preboot),
        .ce_loc_i      (ce_loc),
        .boot_size_i   (boot_size),
        .prog_wr_sel_o (pws),
        .sec_o         (sec),
        .erase_req_o   (req),
        .erase_mass_o  (mass),
        .erase_page_o  (epage),
        .erase_busy_o  (busy),
        .erase_err_o   (err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        we = 1'b0;
        rst_ni = 1'b0;
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // expected request pushed before the command write
    task automatic expect_erase(input logic m, input logic [6:0] p);
        exp_q.push_back({m, p});
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 4 * N) begin
            n++;
            @(negedge clk);
        end
    endtask

    // monitor: every request must match the next expected item
    always @(negedge clk) begin
        if (rst_ni && req) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8/R9 unexpected request actual=%0h expected=none", {mass, epage});
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if ({mass, epage} !== e) begin
                    errors++;
                    $display("FAIL R10 request actual=%0h expected=%0h", {mass, epage}, e);
                end
            end
        end
    end

    initial begin
        logic [7:0] d;
        int n;

        do_reset();
        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl reset", d, 8'h80);
        rd(A_PAGE, d); chk("R1 page reset", d, 8'h00);
        chk("R1 busy/err/sec reset", {busy, err, sec}, 3'b000);

        // R11 program write select
        wr(A_CTRL, 8'h01);
        chk("R11 prog_wr_sel set", pws, 1'b1);
        wr(A_CTRL, 8'h00);
        chk("R11 prog_wr_sel clear", pws, 1'b0);

        // R4 R10 page erase, busy length, then not re-armed
        wr(A_PAGE, 8'h05);
        expect_erase(1'b0, 7'd5);
        wr(A_CMD, 8'hAA);
        chk("R10 busy after accept", busy, 1'b1);
        busy_len(n);
        chk("R10 busy length", n, N);
        chk("R10 no error", err, 1'b0);
        wr(A_CMD, 8'hAA);
        chk("R4 unarmed page refused err", err, 1'b1);
        chk("R4 unarmed no busy", busy, 1'b0);
        wr(A_PAGE, 8'h06);
        chk("R9 err sticky", err, 1'b1);

        // R5 mass erase
        do_reset();
        wr(A_CMD, 8'h55);
        chk("R5 mass without enable refused", err, 1'b1);
        do_reset();
        wr(A_CTRL, 8'h02);
        expect_erase(1'b1, 7'd0);
        wr(A_CMD, 8'h55);
        rd(A_CTRL, d); chk("R5 enable self-cleared", d[1], 1'b0);
        busy_len(n);
        wr(A_CMD, 8'h55);
        chk("R5 second mass refused", err, 1'b1);

        // R8 unknown code, R10 commands during busy
        do_reset();
        wr(A_CMD, 8'h12);
        chk("R8 unknown code no err", err, 1'b0);
        chk("R8 unknown code no busy", busy, 1'b0);
        wr(A_PAGE, 8'h03);
        expect_erase(1'b0, 7'd3);
        wr(A_CMD, 8'hAA);
        wr(A_PAGE, 8'h04);
        wr(A_CMD, 8'hAA);
        wr(A_CMD, 8'h55);
        chk("R10 busy commands no err", err, 1'b0);
        busy_len(n);
        expect_erase(1'b0, 7'd4);
        wr(A_CMD, 8'hAA);
        chk("R10 later page accepted", busy, 1'b1);
        busy_len(n);

        // R6 high area boundary
        do_reset();
        wr(A_CTRL, 8'h10);
        wr(A_PAGE, 8'd100);
        wr(A_CMD, 8'hAA);
        chk("R6 page at ce_loc refused", err, 1'b1);
        do_reset();
        wr(A_CTRL, 8'h10);
        wr(A_PAGE, 8'd99);
        expect_erase(1'b0, 7'd99);
        wr(A_CMD, 8'hAA);
        chk("R6 page below ce_loc ok", {busy, err}, 2'b10);
        busy_len(n);

        // R7 boot area boundary
        do_reset();
        wr(A_CTRL, 8'h20);
        wr(A_PAGE, 8'd7);
        wr(A_CMD, 8'hAA);
        chk("R7 page in boot refused", err, 1'b1);
        do_reset();
        wr(A_CTRL, 8'h20);
        wr(A_PAGE, 8'd8);
        expect_erase(1'b0, 7'd8);
        wr(A_CMD, 8'hAA);
        chk("R7 page at boot_size ok", {busy, err}, 2'b10);
        busy_len(n);

        // R3 R2 lock behaviour
        do_reset();
        preboot = 1'b0;
        wr(A_CTRL, 8'h30);
        rd(A_CTRL, d); chk("R3 wp set unlocked", d, 8'h30);
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, d); chk("R3 wp clear unlocked", d, 8'h00);
        wr(A_CTRL, 8'h40);
        chk("R2 sec_o set", sec, 1'b1);
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, d); chk("R2 sec write zero ignored", d, 8'h40);
        wr(A_CTRL, 8'h50);
        wr(A_CTRL, 8'h40);
        rd(A_CTRL, d); chk("R3 wp_ce kept under sec", d, 8'h50);
        wr(A_CTRL, 8'h60);
        rd(A_CTRL, d); chk("R3 wp_boot set under sec", d, 8'h70);
        do_reset();
        rd(A_CTRL, d); chk("R2 reset clears sec", d, 8'h00);
        chk("R2 sec_o after reset", sec, 1'b0);

        repeat (2) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule